// File: doc/BRIEF.md
# Temperature Conversion Scheduler

This block decides when a temperature sensor core converts and for how long. A 3-bit rate code picks a continuous conversion period from a seven-entry table, and code zero puts the sensor in shutdown. In shutdown, a one-shot request runs exactly one conversion and then clears itself. A 2-bit resolution code picks the conversion length, which doubles with each added bit. It also picks how many low bits of the result are cleared.

Time is counted in base ticks. A base tick is a strobe that arrives `TICKS_PER_MS` times per millisecond, which must be a multiple of 4 so that the 8.75 ms conversion is a whole number of ticks. The block raises `startPulse` when a conversion begins and holds `busy` while it runs. When the conversion ends it raises `donePulse` and updates `resultOut` from the raw 16-bit sample present at that moment, with the bits below the chosen resolution cleared. The LSB weight stays at 1/16 °C. Configuration is written as a set of fields with one write strobe.

Top module: `conv_sched`

## Requirements
- R1: During and right after reset, `busy`, `startPulse`, `donePulse` and `resultOut` are 0 and `busTimeoutEn` is 1. The reset rate is code 5 and the reset resolution is code 3, so the first conversion starts on the first clock edge after reset is released.
- R2: With a nonzero rate code, conversions begin every P ms, counted in base ticks. P is 64000, 32000, 16000, 4000, 1000, 250 and 125 for codes 1 to 7.
- R3: A conversion lasts 35, 70, 140 or 560 base ticks for resolution codes 0, 1, 2 and 3 (at 4 ticks per ms). `busy` rises together with `startPulse`, and `donePulse` follows exactly that many ticks after `startPulse`, in a cycle where `busy` is already low. Each pulse lasts one cycle.
- R4: At done, `resultOut` takes the raw sample with its low bits cleared: 4 bits for code 0, 3 for code 1, 2 for code 2 and none for code 3. The resolution used is the one latched when the conversion started. `resultOut` changes only at done.
- R5: A configuration write with a nonzero rate restarts the period. A conversion starts two cycles after the write strobe, and further conversions follow at the new period from that start.
- R6: Writing rate code 0 while a periodic conversion runs aborts it. `busy` falls two cycles after the strobe, no `donePulse` appears, and no further periodic conversion starts.
- R7: With rate code 0, writing one-shot = 1 starts one conversion two cycles after the strobe. The request clears itself at done, so no second conversion follows.
- R8: A one-shot value written together with a nonzero rate code is discarded. A later switch to shutdown therefore starts nothing.
- R9: A period boundary that falls while a conversion is still busy is skipped. The next conversion starts at the following boundary.
- R10: `busTimeoutEn` is the inverse of the last written `cfgToutOff`, and it updates one cycle after the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baseTick | input | 1 | Timebase strobe, TICKS_PER_MS per millisecond |
| cfgWe | input | 1 | Configuration write strobe |
| cfgRate | input | 3 | Rate code, 0 = shutdown |
| cfgRes | input | 2 | Resolution code, 0..3 = 8, 9, 10, 12 bits |
| cfgOneShot | input | 1 | One-shot request, honoured only with rate 0 |
| cfgToutOff | input | 1 | 1 disables the bus timeout |
| rawSample | input | 16 | Raw temperature sample from the core |
| busy | output | 1 | Conversion in progress |
| startPulse | output | 1 | One-cycle pulse at conversion start |
| donePulse | output | 1 | One-cycle pulse when the result is valid |
| resultOut | output | 16 | Last result, truncated to the resolution |
| busTimeoutEn | output | 1 | Bus timeout enable |

## Verification
With a base tick on every clock, a start falls two cycles after a configuration write strobe. It falls one cycle after reset release, at each period boundary, or on the cycle after a pending restart. The matching done falls exactly the conversion length in ticks after its start. An abort shows as `busy` low two cycles after the strobe, and the timeout flag follows a write by one cycle. The driver computes the cycle number of every expected start and done, and the value of every expected result, from those rules and queues them in time order. The monitor samples on the falling edge, compares every pulse with the head of the queue by cycle number, kind and value, and reports any pulse that arrives when nothing was queued.

// File: rtl/conv_sched_pkg.sv
package conv_sched_pkg;

  typedef enum logic {S_IDLE, S_CONV} schedState_t;

  // control -> datapath
  typedef struct packed {
    logic run;
    logic startConv;
    logic finishConv;
    logic clearOneShot;
  } ctlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic contMode;
    logic kick;
    logic periodWrap;
    logic oneShotReq;
    logic convElapsed;
  } dpStatus_t;

  function automatic int unsigned periodMs(input logic [2:0] code);
    case (code)
      3'd1:    return 64000;
      3'd2:    return 32000;
      3'd3:    return 16000;
      3'd4:    return 4000;
      3'd5:    return 1000;
      3'd6:    return 250;
      3'd7:    return 125;
      default: return 0;
    endcase
  endfunction

  // bits dropped from the result; also the right shift applied to the 12-bit time
  function automatic int unsigned dropBits(input logic [1:0] res);
    case (res)
      2'd0:    return 4;
      2'd1:    return 3;
      2'd2:    return 2;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/conv_sched_dp.sv
module conv_sched_dp
  import conv_sched_pkg::*;
#(
  parameter int TICKS_PER_MS = 4,
  parameter int SAMPLE_W     = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                baseTick,
  input  logic                cfgWe,
  input  logic [2:0]          cfgRate,
  input  logic [1:0]          cfgRes,
  input  logic                cfgOneShot,
  input  logic                cfgToutOff,
  input  logic [SAMPLE_W-1:0] rawSample,
  input  ctlStrobe_t          strobe,
  output dpStatus_t           status,
  output logic [SAMPLE_W-1:0] resultOut,
  output logic                busTimeoutEn
);

  localparam int PERIOD_MAX = 64000 * TICKS_PER_MS;
  localparam int PCNT_W     = $clog2(PERIOD_MAX);
  localparam int CONV_MAX   = 140 * TICKS_PER_MS;
  localparam int CCNT_W     = $clog2(CONV_MAX);

  logic [2:0]          rateCode;
  logic [1:0]          resCode;
  logic [1:0]          convRes;
  logic                toutOff;
  logic                oneShot;
  logic                kick;
  logic [PCNT_W-1:0]   periodCnt;
  logic [CCNT_W-1:0]   convCnt;
  logic [PCNT_W-1:0]   periodLast;
  logic [CCNT_W-1:0]   convLast;
  logic [SAMPLE_W-1:0] keepMask;
  logic [SAMPLE_W-1:0] resultReg;
  logic                contMode;

  assign contMode   = (rateCode != 3'd0);
  assign periodLast = PCNT_W'(periodMs(rateCode) * TICKS_PER_MS - 1);
  assign convLast   = CCNT_W'((CONV_MAX >> dropBits(convRes)) - 1);
  assign keepMask   = ~((SAMPLE_W'(1) << dropBits(convRes)) - SAMPLE_W'(1));

  // configuration fields, pending restart and one-shot request
  always_ff @(posedge clk) begin
    if (rst) begin
      rateCode <= 3'd5;
      resCode  <= 2'd3;
      toutOff  <= 1'b0;
      oneShot  <= 1'b0;
      kick     <= 1'b1;
    end else begin
      if (strobe.clearOneShot) oneShot <= 1'b0;
      if (strobe.startConv)    kick    <= 1'b0;
      if (cfgWe) begin
        rateCode <= cfgRate;
        resCode  <= cfgRes;
        toutOff  <= cfgToutOff;
        oneShot  <= cfgOneShot && (cfgRate == 3'd0);
        kick     <= (cfgRate != 3'd0);
      end
    end
  end

  // period timebase
  always_ff @(posedge clk) begin
    if (rst || cfgWe || !contMode)          periodCnt <= '0;
    else if (strobe.startConv && kick)      periodCnt <= '0;
    else if (baseTick) begin
      if (periodCnt == periodLast)          periodCnt <= '0;
      else                                  periodCnt <= periodCnt + 1'b1;
    end
  end

  // conversion timer and result capture
  always_ff @(posedge clk) begin
    if (rst) begin
      convCnt   <= '0;
      convRes   <= 2'd3;
      resultReg <= '0;
    end else begin
      if (strobe.startConv) begin
        convCnt <= '0;
        convRes <= resCode;
      end else if (strobe.run && baseTick) begin
        convCnt <= convCnt + 1'b1;
      end
      if (strobe.finishConv) resultReg <= rawSample & keepMask;
    end
  end

  assign status.contMode    = contMode;
  assign status.kick        = kick;
  assign status.periodWrap  = contMode && baseTick && (periodCnt == periodLast);
  assign status.oneShotReq  = oneShot;
  assign status.convElapsed = strobe.run && baseTick && (convCnt == convLast);

  assign resultOut    = resultReg;
  assign busTimeoutEn = ~toutOff;

endmodule

// File: rtl/conv_sched_ctl.sv
module conv_sched_ctl
  import conv_sched_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe,
  output logic       busy,
  output logic       startPulse,
  output logic       donePulse
);

  schedState_t state, stateNext;
  logic        isOneShot;
  logic        startCont;
  logic        startOne;

  assign startCont = status.contMode && (status.kick || status.periodWrap);
  assign startOne  = !status.contMode && status.oneShotReq;

  always_comb begin
    stateNext           = state;
    strobe              = '0;
    strobe.run          = (state == S_CONV);
    unique case (state)
      S_IDLE: begin
        if (startCont || startOne) begin
          strobe.startConv = 1'b1;
          stateNext        = S_CONV;
        end
      end
      S_CONV: begin
        if (status.convElapsed) begin
          strobe.finishConv   = 1'b1;
          strobe.clearOneShot = isOneShot;
          stateNext           = S_IDLE;
        end else if (!isOneShot && !status.contMode) begin
          stateNext = S_IDLE;   // shutdown aborts a periodic conversion
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      isOneShot  <= 1'b0;
      startPulse <= 1'b0;
      donePulse  <= 1'b0;
    end else begin
      state      <= stateNext;
      startPulse <= strobe.startConv;
      donePulse  <= strobe.finishConv;
      if (strobe.startConv) isOneShot <= startOne;
    end
  end

  assign busy = (state == S_CONV);

endmodule

// File: rtl/conv_sched.sv
module conv_sched
  import conv_sched_pkg::*;
#(
  parameter int TICKS_PER_MS = 4,
  parameter int SAMPLE_W     = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                baseTick,
  input  logic                cfgWe,
  input  logic [2:0]          cfgRate,
  input  logic [1:0]          cfgRes,
  input  logic                cfgOneShot,
  input  logic                cfgToutOff,
  input  logic [SAMPLE_W-1:0] rawSample,
  output logic                busy,
  output logic                startPulse,
  output logic                donePulse,
  output logic [SAMPLE_W-1:0] resultOut,
  output logic                busTimeoutEn
);

  ctlStrobe_t strobe;
  dpStatus_t  status;

  conv_sched_ctl u_ctl (
    .clk        (clk),
    .rst        (rst),
    .status     (status),
    .strobe     (strobe),
    .busy       (busy),
    .startPulse (startPulse),
    .donePulse  (donePulse)
  );

  conv_sched_dp #(
    .TICKS_PER_MS (TICKS_PER_MS),
    .SAMPLE_W     (SAMPLE_W)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .baseTick     (baseTick),
    .cfgWe        (cfgWe),
    .cfgRate      (cfgRate),
    .cfgRes       (cfgRes),
    .cfgOneShot   (cfgOneShot),
    .cfgToutOff   (cfgToutOff),
    .rawSample    (rawSample),
    .strobe       (strobe),
    .status       (status),
    .resultOut    (resultOut),
    .busTimeoutEn (busTimeoutEn)
  );

endmodule

// File: rtl/conv_sched_chk.sv
module conv_sched_chk #(
  parameter int SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                cfgWe,
  input logic                cfgToutOff,
  input logic                busy,
  input logic                startPulse,
  input logic                donePulse,
  input logic [SAMPLE_W-1:0] resultOut,
  input logic                busTimeoutEn
);

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    startPulse |=> !startPulse);                                   // R3

  AST_START_WITH_BUSY: assert property (@(posedge clk) disable iff (rst)
    startPulse |-> busy);                                          // R3

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    donePulse |-> (!busy && $past(busy)));                         // R3

  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    startPulse |-> !$past(busy));                                  // R9

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !donePulse |-> $stable(resultOut));                            // R4

  AST_TIMEOUT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    cfgWe |=> (busTimeoutEn == !$past(cfgToutOff)));               // R10

endmodule

bind conv_sched conv_sched_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfgWe        (cfgWe),
  .cfgToutOff   (cfgToutOff),
  .busy         (busy),
  .startPulse   (startPulse),
  .donePulse    (donePulse),
  .resultOut    (resultOut),
  .busTimeoutEn (busTimeoutEn)
);

// File: tb/conv_sched_tb.sv
module conv_sched_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        baseTick = 1'b1;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgRate = 3'd0;
  logic [1:0]  cfgRes = 2'd0;
  logic        cfgOneShot = 1'b0;
  logic        cfgToutOff = 1'b0;
  logic [15:0] rawSample = 16'hABCD;
  logic        busy, startPulse, donePulse, busTimeoutEn;
  logic [15:0] resultOut;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    bit          isDone;
    int          at;
    logic [15:0] val;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  conv_sched u_dut (
    .clk(clk), .rst(rst), .baseTick(baseTick), .cfgWe(cfgWe),
    .cfgRate(cfgRate), .cfgRes(cfgRes), .cfgOneShot(cfgOneShot),
    .cfgToutOff(cfgToutOff), .rawSample(rawSample), .busy(busy),
    .startPulse(startPulse), .donePulse(donePulse),
    .resultOut(resultOut), .busTimeoutEn(busTimeoutEn)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, expv);
    end
  endtask

  task automatic pushExp(input bit isDone, input int at, input logic [15:0] val, input string tag);
    expItem_t it;
    it.isDone = isDone; it.at = at; it.val = val; it.tag = tag;
    expQ.push_back(it);
  endtask

  // start at s, done after n ticks (one tick per cycle) with value v
  task automatic expConv(input int s, input int n, input logic [15:0] v, input string tag);
    pushExp(1'b0, s, 16'h0, tag);
    pushExp(1'b1, s + n, v, tag);
  endtask

  task automatic waitUntil(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic cfgWrite(input logic [2:0] rate, input logic [1:0] res,
                          input logic one, input logic tout, output int wcyc);
    wcyc = cyc;
    cfgWe = 1'b1; cfgRate = rate; cfgRes = res; cfgOneShot = one; cfgToutOff = tout;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // monitor: every pulse must match the head of the expectation queue
  always @(negedge clk) begin
    if (!rst && (startPulse || donePulse)) begin
      if (expQ.size() == 0) begin
        check(1'b0, "unexpected pulse R6 R7 R8 R9", {30'd0, donePulse, startPulse}, 0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        check(it.isDone == donePulse, {it.tag, " kind"}, int'(donePulse), int'(it.isDone));
        check(it.at == cyc, {it.tag, " cycle"}, cyc, it.at);
        if (it.isDone) check(resultOut == it.val, {it.tag, " result"}, int'(resultOut), int'(it.val));
      end
    end
  end

  task automatic summary;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired at cycle %0d: actual=hung expected=finished", cyc);
      summary();
    end
  end

  initial begin
    int r, m, w, w2, a, o, o2, p, s, q, t;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 0 && startPulse == 0 && donePulse == 0, "R1 flags in reset", int'(busy), 0);
    check(resultOut == 16'h0, "R1 result in reset", int'(resultOut), 0);
    check(busTimeoutEn == 1'b1, "R1 timeout enabled", int'(busTimeoutEn), 1);
    r = cyc;
    // R1: 1 s rate, 12-bit; R2: 4000-tick period; R3: 560 ticks
    expConv(r + 1, 560, 16'hABCD, "R1 first conversion");
    expConv(r + 4001, 560, 16'hABCD, "R2 1s period");
    rst = 1'b0;
    waitUntil(r + 4600);

    // R5 restart at 125 ms, R3 35 ticks, R4 drop 4 bits, R10 timeout off
    m = cyc;
    expConv(m + 2, 35, 16'hABC0, "R5 restart");
    expConv(m + 502, 35, 16'h8F30, "R2 125ms period R4");
    expConv(m + 1002, 35, 16'h8F30, "R2 125ms period");
    cfgWrite(3'd7, 2'd0, 1'b0, 1'b1, t);
    waitUntil(m + 5);
    check(busTimeoutEn == 1'b0, "R10 timeout disabled", int'(busTimeoutEn), 0);
    waitUntil(m + 100);
    rawSample = 16'h8F37;
    waitUntil(m + 1100);

    // R3 70 ticks, R4 drop 3 bits
    w = cyc;
    rawSample = 16'h1237;
    expConv(w + 2, 70, 16'h1230, "R3 9-bit R4");
    cfgWrite(3'd7, 2'd1, 1'b0, 1'b0, t);
    waitUntil(w + 5);
    check(busTimeoutEn == 1'b1, "R10 timeout re-enabled", int'(busTimeoutEn), 1);
    waitUntil(w + 200);

    // R3 140 ticks, R4 drop 2 bits, R2 250 ms
    w2 = cyc;
    rawSample = 16'h7FFF;
    expConv(w2 + 2, 140, 16'h7FFC, "R3 10-bit R4");
    pushExp(1'b0, w2 + 1002, 16'h0, "R2 250ms period");
    cfgWrite(3'd6, 2'd2, 1'b0, 1'b0, t);
    waitUntil(w2 + 1050);

    // R6 abort by shutdown
    a = cyc;
    cfgWrite(3'd0, 2'd2, 1'b0, 1'b0, t);
    waitUntil(a + 1);
    check(busy == 1'b1, "R6 busy before abort", int'(busy), 1);
    waitUntil(a + 2);
    check(busy == 1'b0, "R6 busy after abort", int'(busy), 0);
    waitUntil(a + 1500);
    check(expQ.size() == 0, "R6 nothing pending", expQ.size(), 0);

    // R7 one-shot at 12 bits
    o = cyc;
    rawSample = 16'h5A5A;
    expConv(o + 2, 560, 16'h5A5A, "R7 one-shot");
    cfgWrite(3'd0, 2'd3, 1'b1, 1'b0, t);
    waitUntil(o + 300);
    check(busy == 1'b1, "R7 busy during one-shot", int'(busy), 1);
    waitUntil(o + 1500);
    check(busy == 1'b0, "R7 no repeat after one-shot", int'(busy), 0);

    // R7 one-shot at 8 bits
    o2 = cyc;
    rawSample = 16'hF00F;
    expConv(o2 + 2, 35, 16'hF000, "R7 one-shot 8-bit R4");
    cfgWrite(3'd0, 2'd0, 1'b1, 1'b0, t);
    waitUntil(o2 + 200);

    // R8 one-shot written with nonzero rate is discarded
    p = cyc;
    expConv(p + 2, 35, 16'hF000, "R8 periodic");
    expConv(p + 502, 35, 16'hF000, "R8 periodic");
    cfgWrite(3'd7, 2'd0, 1'b1, 1'b0, t);
    waitUntil(p + 600);
    cfgWrite(3'd0, 2'd0, 1'b0, 1'b0, t);
    waitUntil(p + 1200);
    check(busy == 1'b0, "R8 no stale one-shot", int'(busy), 0);

    // R9 period boundary during a 560-tick conversion is skipped
    s = cyc;
    rawSample = 16'h1234;
    expConv(s + 2, 560, 16'h1234, "R9 long conversion");
    expConv(s + 1002, 560, 16'h1234, "R9 next boundary");
    cfgWrite(3'd7, 2'd3, 1'b0, 1'b0, t);
    waitUntil(s + 503);
    check(busy == 1'b1, "R9 still busy over boundary", int'(busy), 1);
    waitUntil(s + 1570);
    cfgWrite(3'd0, 2'd3, 1'b0, 1'b0, t);
    waitUntil(s + 1700);

    // R2 rate 5 / 12-bit configuration (enable pattern)
    q = cyc;
    expConv(q + 2, 560, 16'h1234, "R2 enable pattern");
    expConv(q + 4002, 560, 16'h1234, "R2 enable pattern period");
    cfgWrite(3'd5, 2'd3, 1'b0, 1'b0, t);
    waitUntil(q + 4700);

    check(expQ.size() == 0, "R2 R3 missing pulses", expQ.size(), 0);
    summary();
  end

endmodule